// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit

This block is the datapath core of a minimal accumulator machine. It combines the accumulator with a second operand and produces a 4-bit result. The second operand comes from one of two places: a constant carried in the instruction or a nibble read from data memory. A one-bit source select picks between them.

Every function is evaluated at the same time: a sum, both orders of difference, three bitwise combinations, a pass-through of the second operand and the complement of the accumulator. A 3-bit operation code then drives an output multiplexer that chooses one of these candidates.

Alongside the result, the unit reports three flags for the control logic: a carry from the sum, a borrow from either difference, and a zero flag. It holds no state and has no clock. Output values follow the inputs after the combinational delay only.

Top module: `alu_nib_top`

## Requirements
- R1: With op_i = 3'b000, y_o equals (acc_i + B) modulo 2^W, and carry_o is 1 exactly when acc_i + B exceeds 2^W - 1.
- R2: With op_i = 3'b001, y_o equals (acc_i - B) modulo 2^W, and borrow_o is 1 exactly when acc_i is less than B.
- R3: With op_i = 3'b010, y_o equals (B - acc_i) modulo 2^W, and borrow_o is 1 exactly when B is less than acc_i.
- R4: With op_i = 3'b011, 3'b100 and 3'b101, y_o equals the bitwise AND, OR and XOR of acc_i and B respectively.
- R5: With op_i = 3'b110, y_o equals B. With op_i = 3'b111, y_o equals the bitwise complement of acc_i.
- R6: carry_o is 0 for every op_i other than 3'b000, and borrow_o is 0 for every op_i other than 3'b001 and 3'b010.
- R7: zero_o is 1 exactly when the selected y_o is all zeros.
- R8: B is lit_i when src_mem_i is 0 and mem_i when src_mem_i is 1. The operand that is not selected has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | W (4) | Accumulator operand (A) |
| lit_i | input | W (4) | Constant operand taken from the instruction |
| mem_i | input | W (4) | Operand nibble read from data memory |
| src_mem_i | input | 1 | Second-operand source: 0 constant, 1 memory |
| op_i | input | 3 | Operation code |
| y_o | output | W (4) | Selected result |
| carry_o | output | 1 | Carry out of the addition |
| borrow_o | output | 1 | Borrow of the active subtraction |
| zero_o | output | 1 | Result is zero |

## Verification
The bench builds the unit with its default width of four bits. At that width the full input space is 16 accumulator values, 16 constants, both sources and all eight operation codes. The unselected operand is always driven to a value that differs from the selected one, so the sweep also shows that it has no effect. Covering the whole space reaches every carry and borrow boundary, including equal operands, the all-ones wrap and every path that ends in a zero result.

// File: rtl/alu_nib_pkg.sv
package alu_nib_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_AMB   = 3'b001,
    OP_BMA   = 3'b010,
    OP_AND   = 3'b011,
    OP_OR    = 3'b100,
    OP_XOR   = 3'b101,
    OP_PASSB = 3'b110,
    OP_NOTA  = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu_nib_arith.sv
// Parallel adder and both-order subtractors with their carry/borrow bits.
module alu_nib_arith #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic [W-1:0] amb_o,
  output logic         amb_brw_o,
  output logic [W-1:0] bma_o,
  output logic         bma_brw_o
);

  localparam int WE = W + 1;

  logic [WE-1:0] sum_ext;
  logic [WE-1:0] amb_ext;
  logic [WE-1:0] bma_ext;

  always_comb begin
    sum_ext = {1'b0, a_i} + {1'b0, b_i};
    // the extra top bit of a widened difference is set when it wraps below zero
    amb_ext = {1'b0, a_i} - {1'b0, b_i};
    bma_ext = {1'b0, b_i} - {1'b0, a_i};
  end

  assign sum_o     = sum_ext[W-1:0];
  assign carry_o   = sum_ext[W];
  assign amb_o     = amb_ext[W-1:0];
  assign amb_brw_o = amb_ext[W];
  assign bma_o     = bma_ext[W-1:0];
  assign bma_brw_o = bma_ext[W];

endmodule

// File: rtl/alu_nib_logic.sv
// Bitwise candidates, computed alongside the arithmetic ones.
module alu_nib_logic #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] passb_o,
  output logic [W-1:0] nota_o
);

  assign and_o   = a_i & b_i;
  assign or_o    = a_i | b_i;
  assign xor_o   = a_i ^ b_i;
  assign passb_o = b_i;
  assign nota_o  = ~a_i;

endmodule

// File: rtl/alu_nib_sel.sv
// Output multiplexer: picks one candidate and the flags that belong to it.
module alu_nib_sel
  import alu_nib_pkg::*;
#(
  parameter int W = 4
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] sum_i,
  input  logic         carry_i,
  input  logic [W-1:0] amb_i,
  input  logic         amb_brw_i,
  input  logic [W-1:0] bma_i,
  input  logic         bma_brw_i,
  input  logic [W-1:0] and_i,
  input  logic [W-1:0] or_i,
  input  logic [W-1:0] xor_i,
  input  logic [W-1:0] passb_i,
  input  logic [W-1:0] nota_i,
  output logic [W-1:0] y_o,
  output logic         carry_o,
  output logic         borrow_o
);

  always_comb begin
    y_o      = '0;
    carry_o  = 1'b0;
    borrow_o = 1'b0;
    unique case (op_i)
      OP_ADD:   begin y_o = sum_i; carry_o  = carry_i;   end
      OP_AMB:   begin y_o = amb_i; borrow_o = amb_brw_i; end
      OP_BMA:   begin y_o = bma_i; borrow_o = bma_brw_i; end
      OP_AND:   y_o = and_i;
      OP_OR:    y_o = or_i;
      OP_XOR:   y_o = xor_i;
      OP_PASSB: y_o = passb_i;
      OP_NOTA:  y_o = nota_i;
      default:  y_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_nib_top.sv
module alu_nib_top
  import alu_nib_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] lit_i,
  input  logic [W-1:0] mem_i,
  input  logic         src_mem_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         carry_o,
  output logic         borrow_o,
  output logic         zero_o
);

  logic [W-1:0] opb;
  logic [W-1:0] sum, amb, bma;
  logic         cy, amb_brw, bma_brw;
  logic [W-1:0] r_and, r_or, r_xor, r_passb, r_nota;
  alu_op_e      op;

  // second-operand source (R8)
  assign opb = src_mem_i ? mem_i : lit_i;
  assign op  = alu_op_e'(op_i);

  alu_nib_arith #(.W(W)) arith_i (
    .a_i(acc_i), .b_i(opb),
    .sum_o(sum), .carry_o(cy),
    .amb_o(amb), .amb_brw_o(amb_brw),
    .bma_o(bma), .bma_brw_o(bma_brw)
  );

  alu_nib_logic #(.W(W)) logic_i (
    .a_i(acc_i), .b_i(opb),
    .and_o(r_and), .or_o(r_or), .xor_o(r_xor),
    .passb_o(r_passb), .nota_o(r_nota)
  );

  alu_nib_sel #(.W(W)) sel_i (
    .op_i(op),
    .sum_i(sum), .carry_i(cy),
    .amb_i(amb), .amb_brw_i(amb_brw),
    .bma_i(bma), .bma_brw_i(bma_brw),
    .and_i(r_and), .or_i(r_or), .xor_i(r_xor),
    .passb_i(r_passb), .nota_i(r_nota),
    .y_o(y_o), .carry_o(carry_o), .borrow_o(borrow_o)
  );

  // zero flag on the selected result (R7)
  assign zero_o = (y_o == '0);

endmodule

// File: rtl/alu_nib_chk.sv
// Port-level checker; the unit has no clock, so the checks are immediate.
module alu_nib_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] acc_i,
  input logic [W-1:0] lit_i,
  input logic [W-1:0] mem_i,
  input logic         src_mem_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] y_o,
  input logic         carry_o,
  input logic         borrow_o,
  input logic         zero_o
);

  logic [W-1:0] b_sel;
  logic [W:0]   add_ref;

  always_comb begin
    b_sel   = src_mem_i ? mem_i : lit_i;
    add_ref = {1'b0, acc_i} + {1'b0, b_sel};
    if (op_i == 3'b000)
      p_add_carry_r1: assert ({carry_o, y_o} == add_ref);
    if (op_i == 3'b001)
      p_amb_borrow_r2: assert (borrow_o == (acc_i < b_sel) && (y_o + b_sel) == acc_i);
    if (op_i == 3'b010)
      p_bma_borrow_r3: assert (borrow_o == (b_sel < acc_i) && (y_o + acc_i) == b_sel);
    if (op_i != 3'b000)
      p_no_carry_r6: assert (!carry_o);
    if (op_i != 3'b001 && op_i != 3'b010)
      p_no_borrow_r6: assert (!borrow_o);
    p_zero_flag_r7: assert (zero_o == (y_o == '0));
    if (op_i == 3'b110)
      p_pass_src_r8: assert (y_o == b_sel);
  end

endmodule

bind alu_nib_top alu_nib_chk #(.W(W)) chk_i (
  .acc_i(acc_i), .lit_i(lit_i), .mem_i(mem_i), .src_mem_i(src_mem_i),
  .op_i(op_i), .y_o(y_o), .carry_o(carry_o), .borrow_o(borrow_o),
  .zero_o(zero_o)
);

// File: tb/alu_nib_top_tb_top.sv
module alu_nib_top_tb_top;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] acc, lit, mem;
  logic         src_mem;
  logic [2:0]   op;
  logic [W-1:0] y;
  logic         carry, borrow, zero;

  int vectors = 0;
  int fails   = 0;

  alu_nib_top #(.W(W)) dut_i (
    .acc_i(acc), .lit_i(lit), .mem_i(mem), .src_mem_i(src_mem), .op_i(op),
    .y_o(y), .carry_o(carry), .borrow_o(borrow), .zero_o(zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report_end();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual running expected done");
    report_end();
  end

  task automatic check(input string req, input int ey, input bit ec,
                       input bit eb, input bit ez);
    vectors++;
    if (y !== ey[W-1:0] || carry !== ec || borrow !== eb || zero !== ez) begin
      fails++;
      $display("FAIL %s op=%0d acc=%0d lit=%0d mem=%0d src=%0b: actual y=%0d c=%0b b=%0b z=%0b expected y=%0d c=%0b b=%0b z=%0b",
               req, op, acc, lit, mem, src_mem, y, carry, borrow, zero,
               ey[W-1:0], ec, eb, ez);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    acc = '0; lit = '0; mem = '0; src_mem = 1'b0; op = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // quiet state: add of zeros gives zero, no flags except zero (R1, R7)
    check("R1/R7 idle", 0, 1'b0, 1'b0, 1'b1);

    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < N; a++) begin
          for (int b = 0; b < N; b++) begin
            int ey;
            bit ec, eb;
            string req;
            @(negedge clk);
            op      = 3'(o);
            src_mem = 1'(s);
            acc     = W'(a);
            // the unselected operand carries a different value (R8)
            if (s == 1) begin mem = W'(b); lit = W'(~b); end
            else        begin lit = W'(b); mem = W'(b + 5); end
            ec = 1'b0; eb = 1'b0;
            case (o)
              0: begin ey = (a + b) % N; ec = (a + b) >= N; req = "R1/R8"; end
              1: begin ey = (a - b + N) % N; eb = a < b;   req = "R2/R6/R8"; end
              2: begin ey = (b - a + N) % N; eb = b < a;   req = "R3/R6/R8"; end
              3: begin ey = a & b;        req = "R4/R6 and"; end
              4: begin ey = a | b;        req = "R4/R6 or"; end
              5: begin ey = a ^ b;        req = "R4/R6 xor"; end
              6: begin ey = b;            req = "R5/R6/R8 pass"; end
              default: begin ey = (N - 1) - a; req = "R5/R6 not"; end
            endcase
            #1;
            check(req, ey, ec, eb, (ey % N) == 0);
          end
        end
      end
    end

    // boundaries: full wrap and equal operands
    @(negedge clk);
    op = 3'b000; src_mem = 1'b0; acc = W'(N - 1); lit = W'(1); mem = '0;
    #1 check("R1 wrap to zero", 0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    op = 3'b001; acc = W'(7); lit = W'(7);
    #1 check("R2 equal operands", 0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    op = 3'b010; acc = W'(0); src_mem = 1'b1; mem = W'(N - 1); lit = '0;
    #1 check("R3 R8 from memory", N - 1, 1'b0, 1'b0, 1'b0);

    report_end();
  end

endmodule